// File: doc/BRIEF.md
# Instruction Field Alteration Unit

This pipeline stage carries out the "alter" operation. An alter instruction presents a 32-bit register value and a 9-bit control word. In the cycle the alter instruction retires, the stage returns an updated register value for write-back. In that value, the destination field, the source field, and the 9-bit group made of opcode, C and Z can each be left alone, stepped up or down, or copied from the other operand field. The stage can also record a substitution for the next instruction in the pipeline.

The substitution applies to the next valid instruction only. It can replace that instruction's destination field, its source field, or its whole 14-bit head (condition, opcode, C, Z, I). It can also supply a result register separate from the destination field, or cancel that instruction's result write. Only the in-flight copy of the instruction is changed. The instruction store is never written. The recorded state is used once and then dropped.

The instruction word is laid out as follows: condition in bits 31:28, opcode in 27:21, C in 20, Z in 19, I in 18, destination field in 17:9 and source field in 8:0.

Top module: `field_alter_unit`

## Requirements
- R1: After synchronous reset no substitution is pending. A valid next instruction then appears unchanged on `nx_out`, with `nx_res_ovr` and `nx_wr_cancel` low.
- R2: The control word is split into three codes: result code in bits 8:6, destination code in bits 5:3, source code in bits 2:0. The low two bits of the destination code select the action on D bits 17:9: 00 keeps the field, 01 copies D's source field into it, 10 subtracts one, 11 adds one. The result appears on `d_new` with `d_we` high in the same cycle as `alt_valid`.
- R3: The source code acts on D bits 8:0 in the same way as R2 describes for the destination field, except that 01 copies D's destination field into the source field.
- R4: Every step is modulo 512 within its 9-bit field. No carry or borrow reaches a neighbouring field.
- R5: Result codes 010 and 011 subtract one from, or add one to, the 9-bit group in D bits 27:19.
- R6: Bit 2 of the destination code, or of the source code, makes the next valid instruction take D's field value as it was before the step. That value replaces the matching field of `nx_out`.
- R7: Result codes 100, 110 and 111 raise `nx_res_ovr` for the next valid instruction, with `nx_res_reg` equal to D bits 27:19 as they were before the step. Code 110 also subtracts one from the group in `d_new`, and code 111 also adds one.
- R8: Result code 001 raises `nx_wr_cancel` for the next valid instruction.
- R9: Result code 101 places D bits 31:18 into bits 31:18 of the next valid instruction. D itself is left unchanged.
- R10: The recorded substitution survives cycles with `nx_valid` low. It is applied to exactly one valid instruction and is then cleared. This holds whether or not that instruction is later skipped on its condition.
- R11: D's condition bits 31:28 and I bit 18 never change. A control word of zero leaves D unchanged and records no substitution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_valid | input | 1 | Alter instruction retires this cycle |
| alt_d | input | 32 | Register value read by the alter instruction |
| alt_ctl | input | 9 | Alter control word |
| d_new | output | 32 | Updated register value |
| d_we | output | 1 | Write enable for `d_new` |
| nx_valid | input | 1 | A following instruction is present this cycle |
| nx_word | input | 32 | Following instruction as fetched |
| nx_out | output | 32 | Following instruction after substitution |
| nx_res_ovr | output | 1 | Result register override active |
| nx_res_reg | output | 9 | Override result register address |
| nx_wr_cancel | output | 1 | Suppress the following instruction's result write |

## Verification
The bench steps fields sitting at 511 and at 0. A design that carried across the field boundary would corrupt the neighbouring field or the condition and I bits.

It also combines a step with a substitution. A design that forwarded the post-step value would hand the next instruction a field off by one.

Several idle cycles are inserted between the alter instruction and its target, followed by a second instruction. A design that lost the pending state during idle cycles, or kept it after use, would fail to substitute or would substitute twice.

The result codes 100 and 101 are checked separately from the step codes. A design that confused override with head substitution would rewrite the wrong bits of the next instruction.

// File: rtl/fal_pkg.sv
package fal_pkg;

    localparam int WORD_W = 32;
    localparam int FLD_W  = 9;
    localparam int CTL_W  = 9;
    localparam int HEAD_W = 14;
    localparam int NFLD   = 3;

    localparam int SRC_LO  = 0;
    localparam int DST_LO  = SRC_LO + FLD_W;
    localparam int HEAD_LO = DST_LO + FLD_W;
    localparam int GRP_LO  = HEAD_LO + 1;
    localparam int COND_LO = GRP_LO + FLD_W;

    localparam int IX_SRC = 0;
    localparam int IX_DST = 1;
    localparam int IX_GRP = 2;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_COPY = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_INC  = 2'b11
    } step_e;

    typedef struct packed {
        step_e dst_step;
        logic  dst_sub;
        step_e src_step;
        logic  src_sub;
        step_e grp_step;
        logic  res_sub;
        logic  wr_cancel;
        logic  head_sub;
    } ctl_t;

    typedef struct packed {
        logic              dst_en;
        logic [FLD_W-1:0]  dst;
        logic              src_en;
        logic [FLD_W-1:0]  src;
        logic              res_en;
        logic [FLD_W-1:0]  res;
        logic              cancel;
        logic              head_en;
        logic [HEAD_W-1:0] head;
    } pend_t;

    function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] c);
        ctl_t       o;
        logic [2:0] r;
        r           = c[8:6];
        o.dst_step  = step_e'(c[4:3]);
        o.dst_sub   = c[5];
        o.src_step  = step_e'(c[1:0]);
        o.src_sub   = c[2];
        o.grp_step  = r[1] ? step_e'({1'b1, r[0]}) : STEP_NONE;
        o.res_sub   = r[2] && (r != 3'b101);
        o.wr_cancel = (r == 3'b001);
        o.head_sub  = (r == 3'b101);
        return o;
    endfunction

endpackage

// File: rtl/fal_field_step.sv
module fal_field_step
    import fal_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] other,
    input  step_e        step,
    output logic [W-1:0] nxt
);

    always_comb begin
        unique case (step)
            STEP_NONE: nxt = own;
            STEP_COPY: nxt = other;
            STEP_DEC:  nxt = own - W'(1);
            STEP_INC:  nxt = own + W'(1);
            default:   nxt = own;
        endcase
    end

endmodule

// File: rtl/fal_pending.sv
module fal_pending
    import fal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  ctl_t              cw,
    input  logic [WORD_W-1:0] d_cur,
    input  logic              nx_valid,
    input  logic [WORD_W-1:0] nx_word,
    output logic [WORD_W-1:0] nx_out,
    output logic              nx_res_ovr,
    output logic [FLD_W-1:0]  nx_res_reg,
    output logic              nx_wr_cancel
);

    pend_t pend_q;
    pend_t pend_d;
    logic  pend_any;

    // capture pre-step field values
    always_comb begin
        pend_d         = '0;
        pend_d.dst_en  = cw.dst_sub;
        pend_d.dst     = d_cur[DST_LO +: FLD_W];
        pend_d.src_en  = cw.src_sub;
        pend_d.src     = d_cur[SRC_LO +: FLD_W];
        pend_d.res_en  = cw.res_sub;
        pend_d.res     = d_cur[GRP_LO +: FLD_W];
        pend_d.cancel  = cw.wr_cancel;
        pend_d.head_en = cw.head_sub;
        pend_d.head    = d_cur[HEAD_LO +: HEAD_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (load)
            pend_q <= pend_d;
        else if (nx_valid)
            pend_q <= '0;
    end

    assign pend_any = pend_q.dst_en | pend_q.src_en | pend_q.res_en
                    | pend_q.cancel | pend_q.head_en;

    always_comb begin
        nx_out = nx_word;
        if (nx_valid) begin
            if (pend_q.head_en) nx_out[HEAD_LO +: HEAD_W] = pend_q.head;
            if (pend_q.dst_en)  nx_out[DST_LO +: FLD_W]   = pend_q.dst;
            if (pend_q.src_en)  nx_out[SRC_LO +: FLD_W]   = pend_q.src;
        end
    end

    assign nx_res_ovr   = nx_valid & pend_q.res_en;
    assign nx_res_reg   = pend_q.res;
    assign nx_wr_cancel = nx_valid & pend_q.cancel;

    p_pass_clean_r1: assert property (@(posedge clk) disable iff (rst)
        (nx_valid && !pend_any) |-> (nx_out == nx_word && !nx_res_ovr && !nx_wr_cancel));

    p_one_shot_r10: assert property (@(posedge clk) disable iff (rst)
        (nx_valid && !load) |=> !pend_any);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!nx_valid && !load) |=> $stable(pend_q));

    p_dst_prestep_r6: assert property (@(posedge clk) disable iff (rst)
        (load && cw.dst_sub) |=> (nx_valid -> nx_out[DST_LO +: FLD_W] == $past(d_cur[DST_LO +: FLD_W])));

    p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
        (load && cw.wr_cancel) |=> (nx_valid -> nx_wr_cancel));

endmodule

// File: rtl/field_alter_unit.sv
module field_alter_unit
    import fal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alt_valid,
    input  logic [31:0]       alt_d,
    input  logic [8:0]        alt_ctl,
    output logic [31:0]       d_new,
    output logic              d_we,
    input  logic              nx_valid,
    input  logic [31:0]       nx_word,
    output logic [31:0]       nx_out,
    output logic              nx_res_ovr,
    output logic [8:0]        nx_res_reg,
    output logic              nx_wr_cancel
);

    ctl_t             cw;
    logic [FLD_W-1:0] fld_cur [NFLD];
    logic [FLD_W-1:0] fld_oth [NFLD];
    logic [FLD_W-1:0] fld_new [NFLD];
    step_e            fld_stp [NFLD];

    assign cw = decode_ctl(alt_ctl);

    always_comb begin
        fld_cur[IX_SRC] = alt_d[SRC_LO +: FLD_W];
        fld_cur[IX_DST] = alt_d[DST_LO +: FLD_W];
        fld_cur[IX_GRP] = alt_d[GRP_LO +: FLD_W];
        fld_oth[IX_SRC] = alt_d[DST_LO +: FLD_W];
        fld_oth[IX_DST] = alt_d[SRC_LO +: FLD_W];
        fld_oth[IX_GRP] = alt_d[GRP_LO +: FLD_W];
        fld_stp[IX_SRC] = cw.src_step;
        fld_stp[IX_DST] = cw.dst_step;
        fld_stp[IX_GRP] = cw.grp_step;
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_step
        fal_field_step #(.W(FLD_W)) u_step (
            .own   (fld_cur[g]),
            .other (fld_oth[g]),
            .step  (fld_stp[g]),
            .nxt   (fld_new[g])
        );
    end

    assign d_new = {alt_d[WORD_W-1:COND_LO], fld_new[IX_GRP], alt_d[HEAD_LO],
                    fld_new[IX_DST], fld_new[IX_SRC]};
    assign d_we  = alt_valid;

    fal_pending u_pend (
        .clk          (clk),
        .rst          (rst),
        .load         (alt_valid),
        .cw           (cw),
        .d_cur        (alt_d),
        .nx_valid     (nx_valid),
        .nx_word      (nx_word),
        .nx_out       (nx_out),
        .nx_res_ovr   (nx_res_ovr),
        .nx_res_reg   (nx_res_reg),
        .nx_wr_cancel (nx_wr_cancel)
    );

    p_dst_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (alt_valid && cw.dst_step == STEP_INC && alt_d[DST_LO +: FLD_W] == '1)
        |-> (d_new[DST_LO +: FLD_W] == '0 && d_new[WORD_W-1:GRP_LO] == alt_d[WORD_W-1:GRP_LO]));

    p_src_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (alt_valid && cw.src_step == STEP_DEC && alt_d[SRC_LO +: FLD_W] == '0)
        |-> (d_new[SRC_LO +: FLD_W] == '1));

    p_zero_ctl_r11: assert property (@(posedge clk) disable iff (rst)
        (alt_valid && alt_ctl == '0) |-> (d_new == alt_d));

endmodule

// File: tb/sim_field_alter_unit.sv
module sim_field_alter_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alt_valid = 1'b0;
    logic [31:0] alt_d = '0;
    logic [8:0]  alt_ctl = '0;
    logic [31:0] d_new;
    logic        d_we;
    logic        nx_valid = 1'b0;
    logic [31:0] nx_word = '0;
    logic [31:0] nx_out;
    logic        nx_res_ovr;
    logic [8:0]  nx_res_reg;
    logic        nx_wr_cancel;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    field_alter_unit u0 (.*);

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [6:0] op,
                                       input logic c, input logic z, input logic i,
                                       input logic [8:0] dst, input logic [8:0] src);
        return {cond, op, c, z, i, dst, src};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_alter(input string tag, input logic [31:0] d, input logic [8:0] ctl,
                            input logic [31:0] exp_d);
        @(negedge clk);
        alt_valid = 1'b1; alt_d = d; alt_ctl = ctl;
        #2;
        chk({tag, " d_new"}, d_new, exp_d);
        chk({tag, " d_we"}, {31'b0, d_we}, 32'd1);
        @(posedge clk); #1;
        alt_valid = 1'b0; alt_ctl = '0;
    endtask

    task automatic do_next(input string tag, input logic [31:0] w, input logic [31:0] exp_w,
                           input logic exp_ovr, input logic [8:0] exp_reg, input logic exp_can);
        @(negedge clk);
        nx_valid = 1'b1; nx_word = w;
        #2;
        chk({tag, " nx_out"}, nx_out, exp_w);
        chk({tag, " ovr"}, {31'b0, nx_res_ovr}, {31'b0, exp_ovr});
        if (exp_ovr) chk({tag, " res_reg"}, {23'b0, nx_res_reg}, {23'b0, exp_reg});
        chk({tag, " cancel"}, {31'b0, nx_wr_cancel}, {31'b0, exp_can});
        @(posedge clk); #1;
        nx_valid = 1'b0;
    endtask

    localparam logic [31:0] WA = 32'h5A5A_C3C3;
    localparam logic [31:0] WB = 32'h1234_5678;

    task automatic t_reset;
        do_next("R1 reset pass", WA, WA, 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_dst_ops;
        logic [31:0] d = mk(4'hA, 7'h15, 1, 0, 1, 9'h010, 9'h1F0);
        do_alter("R2 dst keep", d, 9'b000_000_000, d);
        do_alter("R2 dst copy", d, 9'b000_001_000, mk(4'hA, 7'h15, 1, 0, 1, 9'h1F0, 9'h1F0));
        do_alter("R2 dst dec",  d, 9'b000_010_000, mk(4'hA, 7'h15, 1, 0, 1, 9'h00F, 9'h1F0));
        do_alter("R2 dst inc",  d, 9'b000_011_000, mk(4'hA, 7'h15, 1, 0, 1, 9'h011, 9'h1F0));
    endtask

    task automatic t_src_ops;
        logic [31:0] d = mk(4'hA, 7'h15, 1, 0, 1, 9'h010, 9'h1F0);
        do_alter("R3 src copy", d, 9'b000_000_001, mk(4'hA, 7'h15, 1, 0, 1, 9'h010, 9'h010));
        do_alter("R3 src dec",  d, 9'b000_000_010, mk(4'hA, 7'h15, 1, 0, 1, 9'h010, 9'h1EF));
        do_alter("R3 src inc",  d, 9'b000_000_011, mk(4'hA, 7'h15, 1, 0, 1, 9'h010, 9'h1F1));
    endtask

    task automatic t_wrap;
        do_alter("R4 dst wrap", mk(4'h6, 7'h22, 0, 1, 1, 9'h1FF, 9'h000), 9'b000_011_000,
                 mk(4'h6, 7'h22, 0, 1, 1, 9'h000, 9'h000));
        do_alter("R4 src wrap", mk(4'h6, 7'h22, 0, 1, 1, 9'h000, 9'h000), 9'b000_000_010,
                 mk(4'h6, 7'h22, 0, 1, 1, 9'h000, 9'h1FF));
        do_alter("R4 R11 grp wrap", mk(4'h9, 7'h7F, 1, 1, 1, 9'h1FF, 9'h1FF), 9'b011_000_000,
                 mk(4'h9, 7'h00, 0, 0, 1, 9'h1FF, 9'h1FF));
    endtask

    task automatic t_grp;
        logic [31:0] d = mk(4'h2, 7'h15, 1, 0, 0, 9'h0AB, 9'h0CD);
        do_alter("R5 grp dec", d, 9'b010_000_000, mk(4'h2, 7'h15, 0, 1, 0, 9'h0AB, 9'h0CD));
        do_alter("R5 grp inc", d, 9'b011_000_000, mk(4'h2, 7'h15, 1, 1, 0, 9'h0AB, 9'h0CD));
        do_next("R5 no subst", WA, WA, 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_subst;
        do_alter("R6 step+sub", mk(4'h1, 7'h05, 0, 0, 0, 9'h020, 9'h033), 9'b000_111_110,
                 mk(4'h1, 7'h05, 0, 0, 0, 9'h021, 9'h032));
        do_next("R6 prestep fields", WB, {WB[31:18], 9'h020, 9'h033}, 1'b0, 9'h0, 1'b0);
        do_next("R10 used once", WB, WB, 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_resovr;
        logic [31:0] d = mk(4'h2, 7'h15, 1, 0, 0, 9'h0AB, 9'h0CD);
        do_alter("R7 ovr inc", d, 9'b111_000_000, mk(4'h2, 7'h15, 1, 1, 0, 9'h0AB, 9'h0CD));
        do_next("R7 ovr prestep", WA, WA, 1'b1, 9'h056, 1'b0);
        do_alter("R7 ovr only", d, 9'b100_000_000, d);
        do_next("R7 ovr 100", WB, WB, 1'b1, 9'h056, 1'b0);
        do_alter("R7 ovr dec", d, 9'b110_000_000, mk(4'h2, 7'h15, 0, 1, 0, 9'h0AB, 9'h0CD));
        do_next("R7 ovr 110", WB, WB, 1'b1, 9'h056, 1'b0);
    endtask

    task automatic t_cancel;
        logic [31:0] d = mk(4'h7, 7'h33, 1, 1, 0, 9'h101, 9'h102);
        do_alter("R8 cancel d", d, 9'b001_000_000, d);
        do_next("R8 cancel set", WA, WA, 1'b0, 9'h0, 1'b1);
        do_next("R8 R10 cancel gone", WA, WA, 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_head;
        logic [31:0] d = mk(4'h3, 7'h44, 0, 1, 1, 9'h111, 9'h122);
        logic [31:0] w = mk(4'hF, 7'h01, 1, 0, 0, 9'h0AA, 9'h055);
        do_alter("R9 head d", d, 9'b101_000_000, d);
        do_next("R9 head sub", w, mk(4'h3, 7'h44, 0, 1, 1, 9'h0AA, 9'h055), 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_hold;
        logic [31:0] d = mk(4'h4, 7'h10, 0, 0, 0, 9'h0F0, 9'h00F);
        do_alter("R10 hold d", d, 9'b001_100_100, d);
        repeat (3) @(posedge clk);
        do_next("R10 after idle", WA, {WA[31:18], 9'h0F0, 9'h00F}, 1'b0, 9'h0, 1'b1);
        do_next("R10 cleared", WA, WA, 1'b0, 9'h0, 1'b0);
    endtask

    task automatic t_zero;
        logic [31:0] d = 32'hDEAD_BEEF;
        do_alter("R11 zero ctl", d, 9'b000_000_000, d);
        do_next("R11 zero no subst", WB, WB, 1'b0, 9'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_dst_ops();
        t_src_ops();
        t_wrap();
        t_grp();
        t_subst();
        t_resovr();
        t_cancel();
        t_head();
        t_hold();
        t_zero();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule